// File: doc/BRIEF.md
# Register Rename Map Table

This block holds the speculative mapping from architectural register indices to physical register tags for one register class of an out-of-order core. When dispatch asks to rename a destination register, the block reads the tag currently held for that index, takes a fresh tag from the head of an external free-list FIFO, stores the fresh tag in the entry, and returns the pair (new tag, previous tag) one cycle later. Retirement logic uses the previous tag to return that register to the free list once the renaming instruction commits.

An optional hard-wired zero register is never renamed. A request for it pops nothing from the free list, leaves the table alone and reports the existing tag as both the new and the previous mapping. A class with no zero register, such as condition codes, sets the zero-enable parameter low, and then every index is renamed. One instance is built per register class, each with its own free list. A combinational source read port serves operand lookup, and a rollback write port lets recovery logic restore an entry.

Top module: `rename_map_table`

## Requirements
- R1: After reset, architectural index i maps to physical tag i, so the zero register (index ZERO_IDX) holds tag ZERO_IDX.
- R2: `src_tag` gives, without a clock edge, the tag stored for `src_arch`; a rename or rollback of that index in the same cycle shows only from the next cycle on.
- R3: `fl_pop` is high in exactly the cycles where a rename of a non-zero index is accepted (`ren_valid` and `ren_ready` both high), and it is never high without `fl_valid`.
- R4: An accepted non-zero rename writes `fl_tag` into the entry for `ren_arch`, visible at the source port from the next cycle.
- R5: One cycle after each accepted rename, `rsp_valid` is high for one cycle with `rsp_new_tag` equal to the tag written and `rsp_prev_tag` equal to the tag held before the rename; `rsp_valid` is low otherwise.
- R6: With ZERO_EN = 1, a rename of index ZERO_IDX is accepted even when `fl_valid` is low, raises no `fl_pop`, leaves the entry unchanged, and responds with `rsp_new_tag` equal to `rsp_prev_tag`.
- R7: A rename of a non-zero index while `fl_valid` is low is refused: `ren_ready` is low, no pop occurs, no response follows and the entry is unchanged.
- R8: A rollback (`rb_valid`) writes `rb_tag` into entry `rb_arch`; when a rename targets the same index in the same cycle, `ren_ready` is low and the rollback value is what the entry holds afterwards.
- R9: With ZERO_EN = 0, every index including 0 is renamed through the free list.
- R10: A rollback and an accepted rename to different indices in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_arch | input | AW | Architectural destination index to rename |
| ren_ready | output | 1 | Request can be accepted this cycle |
| fl_valid | input | 1 | Free list holds at least one tag |
| fl_tag | input | PW | Tag at the head of the free list |
| fl_pop | output | 1 | Remove the head tag from the free list |
| rsp_valid | output | 1 | Rename response present |
| rsp_new_tag | output | PW | Tag now mapped to the renamed index |
| rsp_prev_tag | output | PW | Tag mapped before the rename |
| src_arch | input | AW | Architectural source index to look up |
| src_tag | output | PW | Current tag for src_arch |
| rb_valid | input | 1 | Rollback write present |
| rb_arch | input | AW | Entry to restore |
| rb_tag | input | PW | Tag to restore into the entry |

## Verification
The hardest cases to reach are collisions in a single cycle: a rollback and a rename aimed at one index, a source lookup of an index being renamed, and a zero-register rename while the free list is empty. Random stimulus draws indices from a narrow pool so that rename, rollback and source indices coincide often, and it holds the free list empty in some cycles by masking its valid. Directed cycles then force each collision once, and a second instance with the zero register disabled confirms that index 0 is renamed.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

  typedef enum logic [1:0] {
    RN_IDLE  = 2'd0,
    RN_FRESH = 2'd1,
    RN_ZERO  = 2'd2,
    RN_STALL = 2'd3
  } rn_kind_e;

  // Tag held by an entry after reset: identity mapping.
  function automatic int rmt_init_tag(input int idx);
    return idx;
  endfunction

  // A request may proceed when no rollback collides with it and it either
  // needs no fresh tag or one is available.
  function automatic logic rmt_may_accept(input logic zero_hit,
                                          input logic fl_avail,
                                          input logic rb_clash);
    return !rb_clash && (zero_hit || fl_avail);
  endfunction

endpackage

// File: rtl/rmt_table.sv
module rmt_table
  import rmt_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int AW       = 5,
  parameter int PW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  output logic [PW-1:0] rd_a_tag,
  input  logic [AW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_b_tag,
  input  logic          rn_we,
  input  logic [AW-1:0] rn_idx,
  input  logic [PW-1:0] rn_tag,
  input  logic          rb_we,
  input  logic [AW-1:0] rb_idx,
  input  logic [PW-1:0] rb_tag
);

  logic [PW-1:0] ent_flat [NUM_ARCH];

  for (genvar e = 0; e < NUM_ARCH; e++) begin : g_ent
    logic          rb_hit;
    logic          rn_hit;
    logic [PW-1:0] q;

    assign rb_hit = rb_we && (rb_idx == AW'(e));
    assign rn_hit = rn_we && (rn_idx == AW'(e));

    // Rollback outranks rename on the same entry.
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= PW'(rmt_init_tag(e));
      else if (rb_hit) q <= rb_tag;
      else if (rn_hit) q <= rn_tag;
    end

    assign ent_flat[e] = q;
  end

  assign rd_a_tag = ent_flat[rd_a_idx];
  assign rd_b_tag = ent_flat[rd_b_idx];

  // R8: a rollback always lands, whatever else targets the entry.
  assert_rollback_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |=> (ent_flat[$past(rb_idx)] == $past(rb_tag)));

  // R4: a rename without a colliding rollback stores its tag.
  assert_rename_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_we && !(rb_we && rb_idx == rn_idx)) |=> (ent_flat[$past(rn_idx)] == $past(rn_tag)));

endmodule

// File: rtl/rmt_rename_ctrl.sv
module rmt_rename_ctrl
  import rmt_pkg::*;
#(
  parameter int AW       = 5,
  parameter int PW       = 6,
  parameter bit ZERO_EN  = 1'b1,
  parameter int ZERO_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  input  logic          fl_valid,
  input  logic [PW-1:0] fl_tag,
  output logic          fl_pop,
  input  logic          rb_valid,
  input  logic [AW-1:0] rb_arch,
  input  logic [PW-1:0] prev_tag,
  output logic          tbl_we,
  output logic [AW-1:0] tbl_idx,
  output logic [PW-1:0] tbl_tag,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_new_tag,
  output logic [PW-1:0] rsp_prev_tag
);

  logic          is_zero;
  logic          rb_clash;
  logic          may_go;
  rn_kind_e      kind;
  logic [PW-1:0] new_tag_d;

  if (ZERO_EN) begin : g_zero
    assign is_zero = (ren_arch == AW'(ZERO_IDX));
  end else begin : g_nozero
    assign is_zero = 1'b0;
  end

  assign rb_clash = rb_valid && (rb_arch == ren_arch);
  assign may_go   = rmt_may_accept(is_zero, fl_valid, rb_clash);

  always_comb begin
    if (!ren_valid)   kind = RN_IDLE;
    else if (!may_go) kind = RN_STALL;
    else if (is_zero) kind = RN_ZERO;
    else              kind = RN_FRESH;
  end

  assign ren_ready = may_go;
  assign fl_pop    = (kind == RN_FRESH);
  assign tbl_we    = (kind == RN_FRESH);
  assign tbl_idx   = ren_arch;
  assign tbl_tag   = fl_tag;
  assign new_tag_d = (kind == RN_FRESH) ? fl_tag : prev_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_new_tag  <= '0;
      rsp_prev_tag <= '0;
    end else begin
      rsp_valid    <= (kind == RN_FRESH) || (kind == RN_ZERO);
      rsp_new_tag  <= new_tag_d;
      rsp_prev_tag <= prev_tag;
    end
  end

  assert_pop_needs_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |-> (fl_valid && ren_valid));

  assert_zero_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && is_zero) |-> !fl_pop);

  assert_empty_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_zero && !fl_valid) |-> !ren_ready);

  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready) |=> rsp_valid);

  assert_rsp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ren_valid && ren_ready) |=> !rsp_valid);

  assert_zero_same_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && is_zero) |=> (rsp_new_tag == rsp_prev_tag));

  assert_clash_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rb_clash |-> !ren_ready);

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int  NUM_ARCH = 32,
  parameter int  NUM_PHYS = 64,
  parameter bit  ZERO_EN  = 1'b1,
  parameter int  ZERO_IDX = 0,
  localparam int AW       = $clog2(NUM_ARCH),
  localparam int PW       = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_arch,
  output logic          ren_ready,
  input  logic          fl_valid,
  input  logic [PW-1:0] fl_tag,
  output logic          fl_pop,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_new_tag,
  output logic [PW-1:0] rsp_prev_tag,
  input  logic [AW-1:0] src_arch,
  output logic [PW-1:0] src_tag,
  input  logic          rb_valid,
  input  logic [AW-1:0] rb_arch,
  input  logic [PW-1:0] rb_tag
);

  logic [PW-1:0] prev_tag;
  logic          tbl_we;
  logic [AW-1:0] tbl_idx;
  logic [PW-1:0] tbl_tag;

  rmt_table #(
    .NUM_ARCH (NUM_ARCH),
    .AW       (AW),
    .PW       (PW)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ren_arch),
    .rd_a_tag (prev_tag),
    .rd_b_idx (src_arch),
    .rd_b_tag (src_tag),
    .rn_we    (tbl_we),
    .rn_idx   (tbl_idx),
    .rn_tag   (tbl_tag),
    .rb_we    (rb_valid),
    .rb_idx   (rb_arch),
    .rb_tag   (rb_tag)
  );

  rmt_rename_ctrl #(
    .AW       (AW),
    .PW       (PW),
    .ZERO_EN  (ZERO_EN),
    .ZERO_IDX (ZERO_IDX)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_arch     (ren_arch),
    .ren_ready    (ren_ready),
    .fl_valid     (fl_valid),
    .fl_tag       (fl_tag),
    .fl_pop       (fl_pop),
    .rb_valid     (rb_valid),
    .rb_arch      (rb_arch),
    .prev_tag     (prev_tag),
    .tbl_we       (tbl_we),
    .tbl_idx      (tbl_idx),
    .tbl_tag      (tbl_tag),
    .rsp_valid    (rsp_valid),
    .rsp_new_tag  (rsp_new_tag),
    .rsp_prev_tag (rsp_prev_tag)
  );

endmodule

// File: tb/rename_map_table_tb_top.sv
`timescale 1ns/1ps
module rename_map_table_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // main instance: 32 arch, 64 phys, zero register at 0
  logic       ren_valid = 0, fl_valid = 0, rb_valid = 0;
  logic [4:0] ren_arch = 0, src_arch = 0, rb_arch = 0;
  logic [5:0] fl_tag = 0, rb_tag = 0;
  logic       ren_ready, fl_pop, rsp_valid;
  logic [5:0] rsp_new_tag, rsp_prev_tag, src_tag;

  rename_map_table dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_ready(ren_ready), .fl_valid(fl_valid), .fl_tag(fl_tag), .fl_pop(fl_pop),
    .rsp_valid(rsp_valid), .rsp_new_tag(rsp_new_tag), .rsp_prev_tag(rsp_prev_tag),
    .src_arch(src_arch), .src_tag(src_tag), .rb_valid(rb_valid),
    .rb_arch(rb_arch), .rb_tag(rb_tag));

  // second instance without a zero register
  logic       c_ren_valid = 0, c_fl_valid = 0;
  logic [2:0] c_ren_arch = 0, c_src_arch = 0;
  logic [3:0] c_fl_tag = 0;
  logic       c_ren_ready, c_fl_pop, c_rsp_valid;
  logic [3:0] c_rsp_new, c_rsp_prev, c_src_tag;

  rename_map_table #(.NUM_ARCH(8), .NUM_PHYS(16), .ZERO_EN(1'b0)) dut_cc_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(c_ren_valid), .ren_arch(c_ren_arch),
    .ren_ready(c_ren_ready), .fl_valid(c_fl_valid), .fl_tag(c_fl_tag), .fl_pop(c_fl_pop),
    .rsp_valid(c_rsp_valid), .rsp_new_tag(c_rsp_new), .rsp_prev_tag(c_rsp_prev),
    .src_arch(c_src_arch), .src_tag(c_src_tag), .rb_valid(1'b0),
    .rb_arch(3'd0), .rb_tag(4'd0));

  // bench model
  logic [5:0] exp_map [32];
  logic [5:0] free_q [$];

  function automatic bit want_ready(bit zero, bit avail, bit clash);
    return !clash && (zero || avail);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit rv, logic [4:0] ra, bit rbv, logic [4:0] rba,
                      logic [5:0] rbt, logic [4:0] sa, bit block);
    bit zero, avail, rdy, acc;
    logic [5:0] prev, newt;
    @(negedge clk);
    avail     = !block && (free_q.size() > 0);
    ren_valid = rv; ren_arch = ra;
    rb_valid  = rbv; rb_arch = rba; rb_tag = rbt;
    src_arch  = sa;
    fl_valid  = avail;
    fl_tag    = (free_q.size() > 0) ? free_q[0] : 6'd0;
    #1;
    zero = (ra == 5'd0);
    rdy  = want_ready(zero, avail, rbv && (rba == ra));
    acc  = rv && rdy;
    prev = exp_map[ra];
    newt = zero ? prev : fl_tag;
    check(ren_ready == rdy, "R7/R8 ready", ren_ready, rdy);
    check(fl_pop == (acc && !zero), "R3 pop", fl_pop, acc && !zero);
    check(src_tag == exp_map[sa], "R2 src read", src_tag, exp_map[sa]);
    @(posedge clk);
    #1;
    if (rbv) exp_map[rba] = rbt;
    if (acc && !zero) begin
      if (!(rbv && rba == ra)) exp_map[ra] = newt;
      void'(free_q.pop_front());
      if ($urandom_range(1, 0) == 1) free_q.push_back(prev);
    end
    check(rsp_valid == acc, "R5 rsp valid", rsp_valid, acc);
    if (acc) begin
      check(rsp_new_tag == newt, zero ? "R6 new tag" : "R5 new tag", rsp_new_tag, newt);
      check(rsp_prev_tag == prev, "R5 prev tag", rsp_prev_tag, prev);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) exp_map[i] = 6'(i);
    for (int i = 32; i < 64; i++) free_q.push_back(6'(i));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity mapping after reset
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); src_arch = 5'(i); #1;
      check(src_tag == 6'(i), "R1 reset map", src_tag, i);
    end
    check(rsp_valid == 1'b0, "R5 idle after reset", rsp_valid, 0);

    // R4/R2: rename index 5, src reads it same cycle (old), next cycle (new)
    step(1, 5'd5, 0, 0, 0, 5'd5, 0);
    step(0, 0, 0, 0, 0, 5'd5, 0);
    check(exp_map[5] == 6'd32, "R4 model sanity", exp_map[5], 32);

    // R6: zero register with empty free list
    step(1, 5'd0, 0, 0, 0, 5'd0, 1);
    step(0, 0, 0, 0, 0, 5'd0, 0);

    // R7: non-zero rename with empty free list, then read entry
    step(1, 5'd7, 0, 0, 0, 5'd7, 1);
    step(0, 0, 0, 0, 0, 5'd7, 0);

    // R8: rollback and rename on the same index
    step(1, 5'd9, 1, 5'd9, 6'd50, 5'd9, 0);
    step(0, 0, 0, 0, 0, 5'd9, 0);

    // R10: rollback and rename on different indices
    step(1, 5'd3, 1, 5'd4, 6'd61, 5'd3, 0);
    step(0, 0, 0, 0, 0, 5'd3, 0);
    step(0, 0, 0, 0, 0, 5'd4, 0);

    // random mix over a narrow index pool
    for (int n = 0; n < 600; n++) begin
      logic [4:0] ra, rba, sa;
      ra  = 5'($urandom_range(5, 0));
      rba = 5'($urandom_range(5, 0));
      sa  = 5'($urandom_range(5, 0));
      step($urandom_range(3, 0) != 0, ra, $urandom_range(4, 0) == 0, rba,
           6'($urandom_range(63, 0)), sa, $urandom_range(5, 0) == 0);
    end
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 0, 5'(i), 0);

    // R9: no zero register, index 0 renamed through the free list
    @(negedge clk);
    c_ren_valid = 1; c_ren_arch = 3'd0; c_fl_valid = 1; c_fl_tag = 4'd12; c_src_arch = 3'd0;
    #1;
    check(c_ren_ready == 1'b1, "R9 ready idx0", c_ren_ready, 1);
    check(c_fl_pop == 1'b1, "R9 pop idx0", c_fl_pop, 1);
    @(posedge clk); #1;
    check(c_rsp_valid && c_rsp_new == 4'd12, "R9 new tag", c_rsp_new, 12);
    check(c_rsp_prev == 4'd0, "R9 prev tag", c_rsp_prev, 0);
    @(negedge clk); c_ren_valid = 0; c_fl_valid = 0; #1;
    check(c_src_tag == 4'd12, "R9 entry updated", c_src_tag, 12);
    c_ren_valid = 1; c_ren_arch = 3'd0; #1;
    check(c_ren_ready == 1'b0, "R9 idx0 stalls when empty", c_ren_ready, 0);
    @(negedge clk); c_ren_valid = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule